// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for Ethernet PHYs using the two-wire clock-plus-bidirectional-data scheme of IEEE 802.3 Clause 22. Software reaches it through four 32-bit registers on a simple write-strobe/read-mux port. To run a transaction, software writes the transfer register with the direction, the PHY address, the register address, the write data and a set GO bit. It then polls GO until the bit reads 0. The block derives MDC from the system clock through a programmable divider. It sends the whole frame on the tri-state data pin and, on reads, captures the PHY's turnaround acknowledge and 16 data bits.

The serialiser is a state machine with nine states. ST_IDLE leaves on an accepted GO (start) to ST_PREAMBLE. The machine then moves from state to state on the MDC falling edge that ends the last bit of the current field: ST_PREAMBLE (32 bits) to ST_OPCODE (4) to ST_PHYAD (5) to ST_REGAD (5). From there it goes to ST_TA_WR on a write or ST_TA_RD on a read (2 bits each). ST_TA_WR goes to ST_DATA_WR and ST_TA_RD to ST_DATA_RD (16 bits each), and both return to ST_IDLE (done), at which point the result is written back. A manual override hands the three pin controls to software and lets it read the pin level, for bit-banged access.

Top module: `mdio_master`

## Requirements
- R1: Registers by word address on reg_addr. 0 = control: bit 31 IDLE (read-only), bit 30 ENABLE, bits 15:0 divider. 1 = transfer: bit 31 GO, bit 30 direction (1 write, 0 read), bit 29 ACK, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. 2 = mode: bit 31 manual. 3 = manual pins. After reset the control register reads 0x000000FF, and the transfer and mode registers read 0.
- R2: During a frame MDC has a period of E+1 system clocks, where E is the divider, or 1 when the divider is 0. In each period MDC is low for the first floor(E/2)+1 clocks and high for the rest. The divider value is captured when the frame starts.
- R3: A frame drives 32 preamble ones, then opcode 0110 (read) or 0101 (write), then the PHY address and then the register address, each MSB first. Data driven by the master changes together with the MDC falling edge.
- R4: On a write the master drives the turnaround 1 then 0 and then the 16 data bits MSB first. The output enable stays high from the first preamble bit to the end of the last data bit and drops when the frame ends.
- R5: On a read the output enable drops after the register address. The pin is sampled on MDC rising edges. A low level in the second turnaround bit sets ACK, and the 16 data bits that follow are stored in the data field.
- R6: On a read with no acknowledge the frame still runs its full 64 MDC periods. The data field then reads 0xFFFF and ACK reads 0.
- R7: GO reads 1 from the cycle after the accepting write until the frame ends (64 MDC periods), then reads 0. A transfer write is accepted only when it has bit 31 set, ENABLE is 1 and no frame is running. Any other transfer write changes nothing.
- R8: IDLE reads 1 exactly when ENABLE is 1 and no frame is running. Clearing ENABLE during a frame lets that frame finish unchanged.
- R9: Outside manual mode and with no frame running, MDC is low and the output enable is low.
- R10: In manual mode (mode bit 31 = 1) the pins follow the manual register: bit 2 drives MDC, bit 1 the output enable and bit 0 the data out. Reading that register returns bits 2 and 1 as written and the live pin level in bit 0.
- R11: A completed write frame leaves ACK at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_oe_o | output | 1 | Data pin output enable |
| mdio_do_o | output | 1 | Data pin output value |
| mdio_di_i | input | 1 | Data pin input level |

## Verification
Frames are run at divider values 3, 4 and 0 (taken as 1). These separate an even and an odd period and the clamped case, and each one fixes where the rising-edge sample falls inside the MDC period. Write frames with mixed data patterns are compared bit for bit against the expected serial stream. Read frames are run with an acknowledging PHY model and with a silent one, which separates the ACK/data path from the all-ones fallback. Two cases check that ignored input is really ignored: a competing transfer write and a cleared ENABLE arrive in the middle of a frame, and both the pin stream and the final register contents must stay unchanged. Manual mode checks that each pin bit maps to the right pin and that the live pin level is read back.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_XFER = 2'd1;
    localparam logic [1:0] A_MODE = 2'd2;
    localparam logic [1:0] A_PINS = 2'd3;

    localparam logic [3:0] OP_READ  = 4'b0110;
    localparam logic [3:0] OP_WRITE = 4'b0101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_TA_WR,
        ST_TA_RD,
        ST_DATA_WR,
        ST_DATA_RD
    } frame_state_e;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_pulse,
    output logic             fall_pulse
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;

    // divider 0 would never toggle MDC, so it is clamped to 1
    always_comb begin
        eff  = (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
        half = eff >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == eff) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // low phase is counts 0..half, high phase half+1..eff
    assign mdc        = run && (cnt_q > half);
    assign rise_pulse = run && (cnt_q == half);
    assign fall_pulse = run && (cnt_q == eff);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16,
    parameter int AFLD_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_dir,
    input  logic [AFLD_W-1:0] phy_addr,
    input  logic [AFLD_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIV_W-1:0]  div,
    input  logic              din,
    output logic              busy,
    output logic              mdc,
    output logic              oe,
    output logic              dout,
    output logic              done,
    output logic              ack_seen,
    output logic [DATA_W-1:0] rx_data
);

    localparam int CNT_W  = $clog2((PRE_LEN > DATA_W) ? PRE_LEN : DATA_W);
    localparam int AIDX_W = $clog2(AFLD_W);
    localparam int DIDX_W = $clog2(DATA_W);

    frame_state_e      state_q;
    logic [CNT_W-1:0]  bit_q;
    logic [DIV_W-1:0]  div_q;
    logic              ack_q;
    logic [DATA_W-1:0] shift_q;
    logic              rise_pulse;
    logic              fall_pulse;
    logic              last;
    logic [3:0]        opcode;

    assign busy   = (state_q != ST_IDLE);
    assign last   = fall_pulse && (bit_q == '0);
    assign opcode = wr_dir ? OP_WRITE : OP_READ;

    mdio_clk_div #(.DIV_W(DIV_W)) clk_div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy),
        .div        (div_q),
        .mdc        (mdc),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    // state register: each field ends on the falling edge of its last bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            div_q   <= '0;
            ack_q   <= 1'b0;
            shift_q <= '0;
        end else begin
            if (rise_pulse) begin
                if (state_q == ST_TA_RD && bit_q == '0) begin
                    ack_q <= !din;
                end
                if (state_q == ST_DATA_RD) begin
                    shift_q <= {shift_q[DATA_W-2:0], din};
                end
            end
            if (fall_pulse && bit_q != '0) begin
                bit_q <= bit_q - 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_PREAMBLE;
                        bit_q   <= CNT_W'(PRE_LEN - 1);
                        div_q   <= div;
                        ack_q   <= 1'b0;
                    end
                end
                ST_PREAMBLE: begin
                    if (last) begin
                        state_q <= ST_OPCODE;
                        bit_q   <= CNT_W'(3);
                    end
                end
                ST_OPCODE: begin
                    if (last) begin
                        state_q <= ST_PHYAD;
                        bit_q   <= CNT_W'(AFLD_W - 1);
                    end
                end
                ST_PHYAD: begin
                    if (last) begin
                        state_q <= ST_REGAD;
                        bit_q   <= CNT_W'(AFLD_W - 1);
                    end
                end
                ST_REGAD: begin
                    if (last) begin
                        state_q <= wr_dir ? ST_TA_WR : ST_TA_RD;
                        bit_q   <= CNT_W'(1);
                    end
                end
                ST_TA_WR: begin
                    if (last) begin
                        state_q <= ST_DATA_WR;
                        bit_q   <= CNT_W'(DATA_W - 1);
                    end
                end
                ST_TA_RD: begin
                    if (last) begin
                        state_q <= ST_DATA_RD;
                        bit_q   <= CNT_W'(DATA_W - 1);
                    end
                end
                ST_DATA_WR, ST_DATA_RD: begin
                    if (last) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // pin outputs from the current state and bit index
    always_comb begin
        oe   = 1'b0;
        dout = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_PREAMBLE: begin oe = 1'b1; dout = 1'b1; end
            ST_OPCODE:   begin oe = 1'b1; dout = opcode[bit_q[1:0]]; end
            ST_PHYAD:    begin oe = 1'b1; dout = phy_addr[bit_q[AIDX_W-1:0]]; end
            ST_REGAD:    begin oe = 1'b1; dout = reg_addr[bit_q[AIDX_W-1:0]]; end
            ST_TA_WR:    begin oe = 1'b1; dout = bit_q[0]; end
            ST_TA_RD:    ;
            ST_DATA_WR:  begin oe = 1'b1; dout = wdata[bit_q[DIDX_W-1:0]]; end
            ST_DATA_RD:  ;
            default:     ;
        endcase
    end

    assign done     = last && (state_q == ST_DATA_WR || state_q == ST_DATA_RD);
    assign ack_seen = ack_q;
    assign rx_data  = shift_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int DIV_RST = 255,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc_o,
    output logic        mdio_oe_o,
    output logic        mdio_do_o,
    input  logic        mdio_di_i
);

    localparam int DATA_W = 16;
    localparam int AFLD_W = 5;
    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

    logic              enable_q;
    logic [DIV_W-1:0]  div_q;
    logic              wr_q;
    logic              ack_q;
    logic [AFLD_W-1:0] regad_q;
    logic [AFLD_W-1:0] phyad_q;
    logic [DATA_W-1:0] data_q;
    logic              manual_q;
    logic              man_mdc_q;
    logic              man_oe_q;
    logic              man_do_q;

    logic              eng_busy;
    logic              eng_mdc;
    logic              eng_oe;
    logic              eng_do;
    logic              eng_done;
    logic              eng_ack;
    logic [DATA_W-1:0] eng_rx;
    logic              start;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata[29:26];

    assign start = reg_wr_en && (reg_addr == A_XFER) && reg_wdata[31]
                   && enable_q && !eng_busy;

    mdio_frame_engine #(
        .DIV_W   (DIV_W),
        .PRE_LEN (PRE_LEN),
        .DATA_W  (DATA_W),
        .AFLD_W  (AFLD_W)
    ) engine_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wr_dir   (wr_q),
        .phy_addr (phyad_q),
        .reg_addr (regad_q),
        .wdata    (data_q),
        .div      (div_q),
        .din      (mdio_di_i),
        .busy     (eng_busy),
        .mdc      (eng_mdc),
        .oe       (eng_oe),
        .dout     (eng_do),
        .done     (eng_done),
        .ack_seen (eng_ack),
        .rx_data  (eng_rx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q  <= 1'b0;
            div_q     <= DIV_INIT;
            wr_q      <= 1'b0;
            ack_q     <= 1'b0;
            regad_q   <= '0;
            phyad_q   <= '0;
            data_q    <= '0;
            manual_q  <= 1'b0;
            man_mdc_q <= 1'b0;
            man_oe_q  <= 1'b0;
            man_do_q  <= 1'b0;
        end else begin
            if (reg_wr_en) begin
                case (reg_addr)
                    A_CTRL: begin
                        enable_q <= reg_wdata[30];
                        div_q    <= reg_wdata[DIV_W-1:0];
                    end
                    A_MODE: manual_q <= reg_wdata[31];
                    A_PINS: begin
                        man_mdc_q <= reg_wdata[2];
                        man_oe_q  <= reg_wdata[1];
                        man_do_q  <= reg_wdata[0];
                    end
                    default: ;
                endcase
            end
            if (start) begin
                wr_q    <= reg_wdata[30];
                ack_q   <= 1'b0;
                regad_q <= reg_wdata[25:21];
                phyad_q <= reg_wdata[20:16];
                data_q  <= reg_wdata[15:0];
            end
            if (eng_done && !wr_q) begin
                ack_q  <= eng_ack;
                data_q <= eng_ack ? eng_rx : '1;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {enable_q && !eng_busy, enable_q,
                                  {(30-DIV_W){1'b0}}, div_q};
            A_XFER:  reg_rdata = {eng_busy, wr_q, ack_q, 3'b000,
                                  regad_q, phyad_q, data_q};
            A_MODE:  reg_rdata = {manual_q, 31'd0};
            default: reg_rdata = {29'd0, man_mdc_q, man_oe_q, mdio_di_i};
        endcase
    end

    assign mdc_o     = manual_q ? man_mdc_q : eng_mdc;
    assign mdio_oe_o = manual_q ? man_oe_q  : eng_oe;
    assign mdio_do_o = manual_q ? man_do_q  : eng_do;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        enable,
    input logic        manual,
    input logic        mdc_o,
    input logic        mdio_oe_o,
    input logic        wr_dir,
    input logic        ack,
    input logic [4:0]  phy,
    input logic [4:0]  regad,
    input logic [15:0] data
);

    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(enable));                                      // R7

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(phy) && $stable(regad) && $stable(wr_dir))); // R7

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !manual) |-> !mdc_o);                                      // R9

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !manual) |-> !mdio_oe_o);                                  // R9

    AST_NOACK_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !wr_dir && !ack) |-> (data == 16'hFFFF));            // R6

    AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && wr_dir) |-> !ack);                                   // R11

endmodule

bind mdio_master mdio_master_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (eng_busy),
    .enable    (enable_q),
    .manual    (manual_q),
    .mdc_o     (mdc_o),
    .mdio_oe_o (mdio_oe_o),
    .wr_dir    (wr_q),
    .ack       (ack_q),
    .phy       (phyad_q),
    .regad     (regad_q),
    .data      (data_q)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc_o;
    logic        mdio_oe_o;
    logic        mdio_do_o;
    logic        mdio_di_i;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mdio_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc_o     (mdc_o),
        .mdio_oe_o (mdio_oe_o),
        .mdio_do_o (mdio_do_o),
        .mdio_di_i (mdio_di_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // expected serial slot value, slot 0 = first preamble bit
    function automatic bit fr_bit(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                                  input logic [15:0] wd, input int s);
        logic [3:0] op;
        op = wr ? 4'b0101 : 4'b0110;
        if (s < 32) return 1'b1;
        if (s < 36) return op[35 - s];
        if (s < 41) return phy[40 - s];
        if (s < 46) return rg[45 - s];
        if (s == 46) return 1'b1;
        if (s == 47) return 1'b0;
        return wd[63 - s];
    endfunction

    function automatic bit fr_oe(input bit wr, input int s);
        return (s < 46) || wr;
    endfunction

    // behavioural PHY: pulls ack low and returns data when it answers
    function automatic bit phy_drv(input bit ackp, input logic [15:0] pd, input int s);
        if (!ackp) return 1'b1;
        if (s == 47) return 1'b0;
        if (s >= 48 && s < 64) return pd[63 - s];
        return 1'b1;
    endfunction

    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input bit ackp, input logic [15:0] pd,
                             input int dreg, input int inject);
        int d;
        int total;
        logic [31:0] v;
        logic [15:0] exp_data;
        d = (dreg == 0) ? 1 : dreg;
        total = 64 * (d + 1);
        wr_reg(2'd1, {1'b1, wr, 1'b0, 3'b000, rg, phy, wd});
        for (int k = 0; k < total; k++) begin
            int s;
            int p;
            s = k / (d + 1);
            p = k % (d + 1);
            reg_wr_en = 1'b0;
            chk("R2 mdc level", {31'd0, mdc_o}, {31'd0, (p > d / 2)});
            chk("R4 R5 output enable", {31'd0, mdio_oe_o}, {31'd0, fr_oe(wr, s)});
            if (fr_oe(wr, s))
                chk("R3 R4 data out", {31'd0, mdio_do_o}, {31'd0, fr_bit(wr, phy, rg, wd, s)});
            rd_reg(2'd1, v);
            chk("R7 GO busy", {31'd0, v[31]}, 32'd1);
            mdio_di_i = phy_drv(ackp, pd, s);
            if (k == 10 && inject == 1) begin
                reg_wr_en = 1'b1;
                reg_addr  = 2'd1;
                reg_wdata = {1'b1, ~wr, 1'b0, 3'b000, ~rg, ~phy, ~wd};
            end
            if (k == 10 && inject == 2) begin
                reg_wr_en = 1'b1;
                reg_addr  = 2'd0;
                reg_wdata = {16'h0000, 16'(dreg)};
            end
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        mdio_di_i = 1'b1;
        chk("R9 mdc low after frame", {31'd0, mdc_o}, 32'd0);
        chk("R9 oe low after frame", {31'd0, mdio_oe_o}, 32'd0);
        rd_reg(2'd1, v);
        exp_data = wr ? wd : (ackp ? pd : 16'hFFFF);
        chk("R7 GO cleared", {31'd0, v[31]}, 32'd0);
        chk("R7 R11 fields", {17'd0, v[30:16]}, {17'd0, wr, (ackp && !wr), 3'b000, rg, phy});
        if (wr)
            chk("R4 data field kept", {16'd0, v[15:0]}, {16'd0, exp_data});
        else if (ackp)
            chk("R5 read data", {16'd0, v[15:0]}, {16'd0, exp_data});
        else
            chk("R6 no-ack data", {16'd0, v[15:0]}, {16'd0, exp_data});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R7 actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n     = 1'b0;
        reg_wr_en = 1'b0;
        reg_addr  = 2'd0;
        reg_wdata = 32'd0;
        mdio_di_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_reg(2'd0, v); chk("R1 control reset", v, 32'h0000_00FF);
        rd_reg(2'd1, v); chk("R1 transfer reset", v, 32'h0000_0000);
        rd_reg(2'd2, v); chk("R1 mode reset", v, 32'h0000_0000);
        chk("R9 mdc reset", {31'd0, mdc_o}, 32'd0);
        chk("R9 oe reset", {31'd0, mdio_oe_o}, 32'd0);

        // R8 enable with divider 3
        wr_reg(2'd0, 32'h4000_0003);
        rd_reg(2'd0, v); chk("R8 idle when enabled", v, 32'hC000_0003);

        run_frame(1'b1, 5'h11, 5'h0A, 16'hA5C3, 1'b0, 16'h0000, 3, 0);
        run_frame(1'b0, 5'h1F, 5'h00, 16'h0000, 1'b1, 16'h5A3C, 3, 0);
        run_frame(1'b0, 5'h00, 5'h1F, 16'h1234, 1'b0, 16'h0000, 3, 0);

        // R2 odd period, R7 competing GO ignored mid-frame
        wr_reg(2'd0, 32'h4000_0004);
        run_frame(1'b0, 5'h05, 5'h12, 16'h0000, 1'b1, 16'h8001, 4, 1);

        // R2 divider 0 clamps to 1; R11 write after acknowledged read
        wr_reg(2'd0, 32'h4000_0000);
        run_frame(1'b1, 5'h1A, 5'h15, 16'h0001, 1'b0, 16'h0000, 0, 0);

        // R8 ENABLE cleared mid-frame
        wr_reg(2'd0, 32'h4000_0003);
        run_frame(1'b1, 5'h02, 5'h07, 16'hFFFF, 1'b0, 16'h0000, 3, 2);
        rd_reg(2'd0, v); chk("R8 idle low when disabled", v, 32'h0000_0003);

        // R7 GO while disabled is ignored
        wr_reg(2'd1, {1'b1, 1'b0, 1'b0, 3'b000, 5'h1C, 5'h03, 16'h7777});
        for (int i = 0; i < 20; i++) begin
            chk("R7 R9 no mdc when disabled", {31'd0, mdc_o}, 32'd0);
            chk("R7 R9 no oe when disabled", {31'd0, mdio_oe_o}, 32'd0);
            @(negedge clk);
        end
        rd_reg(2'd1, v);
        chk("R7 disabled GO ignored", v, {1'b0, 1'b1, 1'b0, 3'b000, 5'h07, 5'h02, 16'hFFFF});

        // R10 manual mode
        wr_reg(2'd2, 32'h8000_0000);
        rd_reg(2'd2, v); chk("R1 mode readback", v, 32'h8000_0000);
        wr_reg(2'd3, 32'h0000_0007);
        chk("R10 manual mdc", {31'd0, mdc_o}, 32'd1);
        chk("R10 manual oe", {31'd0, mdio_oe_o}, 32'd1);
        chk("R10 manual do", {31'd0, mdio_do_o}, 32'd1);
        mdio_di_i = 1'b0;
        rd_reg(2'd3, v); chk("R10 pin read low", v, 32'h0000_0006);
        @(negedge clk);
        wr_reg(2'd3, 32'h0000_0004);
        chk("R10 manual mdc only", {29'd0, mdc_o, mdio_oe_o, mdio_do_o}, 32'h0000_0004);
        mdio_di_i = 1'b1;
        rd_reg(2'd3, v); chk("R10 pin read high", v, 32'h0000_0005);
        @(negedge clk);
        wr_reg(2'd2, 32'h0000_0000);
        chk("R9 mdc low leaving manual", {31'd0, mdc_o}, 32'd0);
        chk("R9 oe low leaving manual", {31'd0, mdio_oe_o}, 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule